// File: doc/BRIEF.md
# Link Power State Controller

This block runs the power state of one end of a point-to-point serial link. The link sits in an active state, U0, or in one of three sleep levels. U1 saves the least power and wakes fastest. U2 sits deeper. U3 is a suspend level with the longest wake time. Entry to U1 or U2 is negotiated with link commands. Either end may ask, and the other end answers with an accept or a reject. U3 is asked for only by the downstream-facing end, and the upstream-facing end must take it. Traffic at a sleeping port starts an exit to U0.

A parameter sets whether the instance faces downstream or upstream. Local policy supplies the request code, permission bits for U1 and U2, a pending-traffic flag and an idle-timer expiry pulse. The block answers partner requests and sends its own requests as one-cycle command pulses. It reports the current level and raises a wake flag while an exit is in progress. A period with nothing to send in U0 is ordinary idle and changes nothing.

Top module: `link_pm_ctrl`

## Requirements
- R1: After reset, and in U0 while no request arrives from either side, `lvl_o` is 0 (codes: 0=U0, 1=U1, 2=U2, 3=U3), `cmd_tx_vld_o` is 0 and `wake_o` is 0.
- R2: In U0 with no pending traffic, a local request code on `pm_req_i` (1=U1, 2=U2, 3=U3) gives a one-cycle command on the next cycle: request-U1 = 0, request-U2 = 1, request-U3 = 2. While the answer is awaited, `lvl_o` stays 0.
- R3: While a request is outstanding, a received reject (code 4) returns the port to plain U0. A received accept (code 3) makes `lvl_o` show the requested level on the cycle after the accept is sampled.
- R4: If no answer arrives within `RSP_TIMEOUT` cycles after the request is sent, the request is dropped. An accept that arrives later leaves `lvl_o` at 0. An accept sampled in the last cycle of the window is still honoured.
- R5: A partner request for U1 or U2 received in U0 is answered on the next cycle. The answer is accept (3) only when no traffic is pending and the matching permission input is 1. Otherwise the answer is reject (4). On accept, `lvl_o` shows the new level in the same cycle as the accept.
- R6: In U1, U2 or U3, pending traffic or any received command raises `wake_o` on the next cycle. `lvl_o` keeps the sleep level until the exit is complete.
- R7: An exit keeps `wake_o` high for exactly `EXIT_U1`, `EXIT_U2` or `EXIT_U3` cycles, where EXIT_U1 < EXIT_U2 < EXIT_U3. After that, `lvl_o` returns to 0 and `wake_o` drops.
- R8: In U1, an idle-timer expiry moves the port to U2 with no command exchange when `u1_demote_en_i` is 1. When it is 0, the port stays in U1.
- R9: An upstream-facing instance never sends request-U3 and ignores a local U3 request. A downstream-facing instance rejects a received request-U3.
- R10: An upstream-facing instance accepts every received request-U3 and enters U3, whatever the traffic flag and the permission inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pm_req_i | input | 2 | Local request: 0 none, 1 U1, 2 U2, 3 U3 |
| allow_u1_i | input | 1 | Local policy permits U1 |
| allow_u2_i | input | 1 | Local policy permits U2 |
| u1_demote_en_i | input | 1 | Permits the move from U1 to U2 on idle expiry |
| idle_exp_i | input | 1 | Idle-timer expiry pulse |
| traffic_pend_i | input | 1 | Local traffic is waiting |
| cmd_rx_vld_i | input | 1 | A link command was received |
| cmd_rx_i | input | 3 | Received command code |
| cmd_tx_vld_o | output | 1 | Command send strobe |
| cmd_tx_o | output | 3 | Command code to send |
| lvl_o | output | 2 | Current link level |
| wake_o | output | 1 | Exit to U0 in progress |

## Verification
Commands and level changes caused by a sampled input are due one cycle later, because both come from the same register stage. The bench drives on the falling edge and checks at the following falling edge. An exit is checked on both sides of its boundary: `wake_o` must still be high after the exit latency minus one cycle, and `lvl_o` must be 0 one cycle later. The timeout is checked at the last cycle that still honours an accept and at a cycle past it. Random partner requests, with random traffic and permission inputs, are compared against a bench function of the R5 rule.

// File: rtl/link_pm_pkg.sv
package link_pm_pkg;
  typedef enum logic [1:0] {LV_U0 = 2'd0, LV_U1 = 2'd1, LV_U2 = 2'd2, LV_U3 = 2'd3} lvl_t;
  typedef enum logic [2:0] {
    CM_REQ_U1 = 3'd0, CM_REQ_U2 = 3'd1, CM_REQ_U3 = 3'd2,
    CM_ACCEPT = 3'd3, CM_REJECT = 3'd4
  } cmd_t;
  typedef enum logic [1:0] {PH_ACT, PH_WAIT, PH_SLEEP, PH_EXIT} phase_t;
endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/lpm_cycle_timer.sv
module lpm_cycle_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i || (dec_i && (cnt_q != '0));
    cnt_d  = load_i ? load_val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && dec_i && !load_i) |=> zero_o);
endmodule

// File: rtl/lpm_accept_policy.sv
module lpm_accept_policy
  import link_pm_pkg::*;
#(
  parameter bit IS_DOWNSTREAM = 1'b1
) (
  input  logic [2:0] cmd_i,
  input  logic       traffic_i,
  input  logic       allow_u1_i,
  input  logic       allow_u2_i,
  output logic       is_req_o,
  output logic       accept_o,
  output lvl_t       want_o
);
  always_comb begin
    is_req_o = 1'b1;
    accept_o = 1'b0;
    want_o   = LV_U0;
    case (cmd_i)
      CM_REQ_U1: begin want_o = LV_U1; accept_o = !traffic_i && allow_u1_i; end
      CM_REQ_U2: begin want_o = LV_U2; accept_o = !traffic_i && allow_u2_i; end
      CM_REQ_U3: begin want_o = LV_U3; accept_o = !IS_DOWNSTREAM; end
      default:   is_req_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/link_pm_ctrl.sv
module link_pm_ctrl
  import link_pm_pkg::*;
#(
  parameter bit IS_DOWNSTREAM = 1'b1,
  parameter int EXIT_U1       = 4,
  parameter int EXIT_U2       = 10,
  parameter int EXIT_U3       = 24,
  parameter int RSP_TIMEOUT   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pm_req_i,
  input  logic       allow_u1_i,
  input  logic       allow_u2_i,
  input  logic       u1_demote_en_i,
  input  logic       idle_exp_i,
  input  logic       traffic_pend_i,
  input  logic       cmd_rx_vld_i,
  input  logic [2:0] cmd_rx_i,
  output logic       cmd_tx_vld_o,
  output logic [2:0] cmd_tx_o,
  output logic [1:0] lvl_o,
  output logic       wake_o
);
  localparam int MAXV = (EXIT_U3 > RSP_TIMEOUT) ? EXIT_U3 : RSP_TIMEOUT;
  localparam int TW   = $clog2(MAXV + 1);
  localparam logic [TW-1:0] RSP_LOAD = TW'(RSP_TIMEOUT - 1);

  logic   rst_i_n;
  phase_t phase_q, phase_d;
  lvl_t   tgt_q, tgt_d;
  logic   txv_q, txv_d;
  logic [2:0] txc_q, txc_d;
  logic   rsp_load, rsp_dec, rsp_zero;
  logic   ex_load, ex_dec, ex_zero;
  logic [TW-1:0] ex_val;
  logic   rx_is_req, rx_accept_ok;
  lvl_t   rx_want;
  logic   loc_ok;

  lpm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  lpm_accept_policy #(.IS_DOWNSTREAM(IS_DOWNSTREAM)) u_pol (
    .cmd_i(cmd_rx_i), .traffic_i(traffic_pend_i),
    .allow_u1_i(allow_u1_i), .allow_u2_i(allow_u2_i),
    .is_req_o(rx_is_req), .accept_o(rx_accept_ok), .want_o(rx_want));

  lpm_cycle_timer #(.W(TW)) u_rsp_tmr (
    .clk(clk), .rst_n(rst_i_n), .load_i(rsp_load), .load_val_i(RSP_LOAD),
    .dec_i(rsp_dec), .zero_o(rsp_zero));

  lpm_cycle_timer #(.W(TW)) u_exit_tmr (
    .clk(clk), .rst_n(rst_i_n), .load_i(ex_load), .load_val_i(ex_val),
    .dec_i(ex_dec), .zero_o(ex_zero));

  function automatic logic [TW-1:0] exit_len(lvl_t l);
    case (l)
      LV_U1:   exit_len = TW'(EXIT_U1 - 1);
      LV_U2:   exit_len = TW'(EXIT_U2 - 1);
      default: exit_len = TW'(EXIT_U3 - 1);
    endcase
  endfunction

  assign loc_ok = (pm_req_i != 2'd0) && !traffic_pend_i &&
                  ((pm_req_i != 2'd3) || IS_DOWNSTREAM);

  always_comb begin
    phase_d  = phase_q;
    tgt_d    = tgt_q;
    txv_d    = 1'b0;
    txc_d    = txc_q;
    rsp_load = 1'b0;
    rsp_dec  = 1'b0;
    ex_load  = 1'b0;
    ex_dec   = 1'b0;
    ex_val   = exit_len(tgt_q);
    case (phase_q)
      PH_ACT: begin
        if (cmd_rx_vld_i && rx_is_req) begin
          txv_d = 1'b1;
          if (rx_accept_ok) begin
            txc_d   = CM_ACCEPT;
            tgt_d   = rx_want;
            phase_d = PH_SLEEP;
          end else begin
            txc_d = CM_REJECT;
          end
        end else if (loc_ok) begin
          txv_d    = 1'b1;
          txc_d    = {1'b0, pm_req_i - 2'd1};
          tgt_d    = lvl_t'(pm_req_i);
          phase_d  = PH_WAIT;
          rsp_load = 1'b1;
        end
      end
      PH_WAIT: begin
        if (cmd_rx_vld_i && cmd_rx_i == CM_ACCEPT) begin
          phase_d = PH_SLEEP;
        end else if ((cmd_rx_vld_i && cmd_rx_i == CM_REJECT) || rsp_zero) begin
          phase_d = PH_ACT;
          tgt_d   = LV_U0;
        end else begin
          rsp_dec = 1'b1;
        end
      end
      PH_SLEEP: begin
        if (traffic_pend_i || cmd_rx_vld_i) begin
          phase_d = PH_EXIT;
          ex_load = 1'b1;
        end else if (tgt_q == LV_U1 && idle_exp_i && u1_demote_en_i) begin
          tgt_d = LV_U2;
        end
      end
      default: begin
        if (ex_zero) begin
          phase_d = PH_ACT;
          tgt_d   = LV_U0;
        end else begin
          ex_dec = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      phase_q <= PH_ACT;
      tgt_q   <= LV_U0;
      txv_q   <= 1'b0;
      txc_q   <= CM_REJECT;
    end else begin
      phase_q <= phase_d;
      tgt_q   <= tgt_d;
      txv_q   <= txv_d;
      txc_q   <= txc_d;
    end
  end

  assign cmd_tx_vld_o = txv_q;
  assign cmd_tx_o     = txc_q;
  assign lvl_o        = (phase_q == PH_SLEEP || phase_q == PH_EXIT) ? tgt_q : LV_U0;
  assign wake_o       = (phase_q == PH_EXIT);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    (phase_q == PH_ACT && !cmd_rx_vld_i && pm_req_i == 2'd0)
      |=> (lvl_o == LV_U0 && !cmd_tx_vld_o));

  p_drop_on_timeout_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (phase_q == PH_WAIT && rsp_zero && !cmd_rx_vld_i) |=> (phase_q == PH_ACT));

  p_busy_reject_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (phase_q == PH_ACT && cmd_rx_vld_i && traffic_pend_i &&
     (cmd_rx_i == CM_REQ_U1 || cmd_rx_i == CM_REQ_U2))
      |=> (cmd_tx_vld_o && cmd_tx_o == CM_REJECT && lvl_o == LV_U0));

  p_wake_on_traffic_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (phase_q == PH_SLEEP && (traffic_pend_i || cmd_rx_vld_i)) |=> wake_o);

  p_exit_lands_u0_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(wake_o) |-> (lvl_o == LV_U0));

  p_no_up_suspend_req_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!IS_DOWNSTREAM) |-> !(cmd_tx_vld_o && cmd_tx_o == CM_REQ_U3));

  p_up_takes_u3_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!IS_DOWNSTREAM && phase_q == PH_ACT && cmd_rx_vld_i && cmd_rx_i == CM_REQ_U3)
      |=> (cmd_tx_vld_o && cmd_tx_o == CM_ACCEPT && lvl_o == LV_U3));
endmodule

// File: tb/test_link_pm_ctrl.sv
module test_link_pm_ctrl;
  localparam int XU1 = 4, XU2 = 10, XU3 = 24, TMO = 16;
  localparam logic [2:0] C_R1 = 3'd0, C_R2 = 3'd1, C_R3 = 3'd2, C_ACC = 3'd3, C_REJ = 3'd4;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic [1:0] d_req, u_req;
  logic d_a1, d_a2, d_en, d_idle, d_tp, d_rxv, u_tp, u_rxv;
  logic [2:0] d_rxc, u_rxc;
  logic d_txv, u_txv, d_wake, u_wake;
  logic [2:0] d_txc, u_txc;
  logic [1:0] d_lvl, u_lvl;

  int total = 0, bad = 0;

  link_pm_ctrl #(.IS_DOWNSTREAM(1'b1), .EXIT_U1(XU1), .EXIT_U2(XU2), .EXIT_U3(XU3),
                 .RSP_TIMEOUT(TMO)) i_link_pm_ctrl (
    .clk(clk), .rst_n(rst_n), .pm_req_i(d_req), .allow_u1_i(d_a1), .allow_u2_i(d_a2),
    .u1_demote_en_i(d_en), .idle_exp_i(d_idle), .traffic_pend_i(d_tp),
    .cmd_rx_vld_i(d_rxv), .cmd_rx_i(d_rxc), .cmd_tx_vld_o(d_txv), .cmd_tx_o(d_txc),
    .lvl_o(d_lvl), .wake_o(d_wake));

  link_pm_ctrl #(.IS_DOWNSTREAM(1'b0), .EXIT_U1(XU1), .EXIT_U2(XU2), .EXIT_U3(XU3),
                 .RSP_TIMEOUT(TMO)) i_link_pm_ctrl_up (
    .clk(clk), .rst_n(rst_n), .pm_req_i(u_req), .allow_u1_i(1'b0), .allow_u2_i(1'b0),
    .u1_demote_en_i(1'b0), .idle_exp_i(1'b0), .traffic_pend_i(u_tp),
    .cmd_rx_vld_i(u_rxv), .cmd_rx_i(u_rxc), .cmd_tx_vld_o(u_txv), .cmd_tx_o(u_txc),
    .lvl_o(u_lvl), .wake_o(u_wake));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic d_rx(input logic [2:0] c);
    d_rxv = 1'b1; d_rxc = c; tick(1); d_rxv = 1'b0;
  endtask

  task automatic d_loc(input logic [1:0] r);
    d_req = r; tick(1); d_req = 2'd0;
  endtask

  task automatic d_exit(input int lat, input int lv);
    d_tp = 1'b1; tick(1); d_tp = 1'b0;
    check("R6 wake raised", d_wake, 1);
    check("R6 level held", d_lvl, lv);
    tick(lat - 1);
    check("R7 still exiting", d_wake, 1);
    tick(1);
    check("R7 back in U0", d_lvl, 0);
    check("R7 wake dropped", d_wake, 0);
  endtask

  function automatic int exp_reply(input int cmd, input bit tp, input bit a1, input bit a2);
    if (tp) return 4;
    if (cmd == 0) return a1 ? 3 : 4;
    return a2 ? 3 : 4;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    d_req = 0; d_a1 = 1; d_a2 = 1; d_en = 0; d_idle = 0; d_tp = 0; d_rxv = 0; d_rxc = 0;
    u_req = 0; u_tp = 0; u_rxv = 0; u_rxc = 0;
    tick(4);
    check("R1 reset level", d_lvl, 0);
    check("R1 reset tx", d_txv, 0);
    check("R1 reset wake", d_wake, 0);
    rst_n = 1'b1;
    tick(20);
    check("R1 idle level", d_lvl, 0);
    check("R1 idle tx", d_txv, 0);

    // R2 and R3: request, reject, stray accept
    d_loc(2'd1);
    check("R2 req strobe", d_txv, 1);
    check("R2 req code", d_txc, C_R1);
    check("R2 level while waiting", d_lvl, 0);
    d_rx(C_REJ);
    check("R3 reject stays U0", d_lvl, 0);
    d_rx(C_ACC);
    check("R3 stray accept ignored", d_lvl, 0);
    d_loc(2'd2);
    check("R2 req U2 code", d_txc, C_R2);
    d_rx(C_ACC);
    check("R3 accept enters U2", d_lvl, 2);
    d_exit(XU2, 2);

    // R4: timeout then late accept; accept on last window cycle
    d_loc(2'd1);
    tick(TMO);
    d_rx(C_ACC);
    check("R4 late accept ignored", d_lvl, 0);
    d_loc(2'd2);
    tick(TMO - 1);
    d_rx(C_ACC);
    check("R4 last-cycle accept", d_lvl, 2);
    d_exit(XU2, 2);

    // R5 and R8
    d_rx(C_R1);
    check("R5 accept code", d_txc, C_ACC);
    check("R5 accept level", d_lvl, 1);
    d_idle = 1'b1; d_en = 1'b0; tick(1);
    check("R8 demote disabled", d_lvl, 1);
    d_en = 1'b1; tick(1); d_idle = 1'b0;
    check("R8 demote to U2", d_lvl, 2);
    d_rx(C_REJ);
    check("R6 rx command wakes", d_wake, 1);
    tick(XU2);
    check("R7 U2 exit done", d_lvl, 0);
    d_en = 1'b0;
    d_rx(C_R1);
    d_exit(XU1, 1);
    d_tp = 1'b1; d_rx(C_R2); d_tp = 1'b0;
    check("R5 busy reject", d_txc, C_REJ);
    check("R5 busy stays U0", d_lvl, 0);
    d_a2 = 1'b0; d_rx(C_R2); d_a2 = 1'b1;
    check("R5 policy reject", d_txc, C_REJ);

    // R9 downstream side of U3
    d_rx(C_R3);
    check("R9 ds rejects U3", d_txc, C_REJ);
    check("R9 ds level", d_lvl, 0);
    d_loc(2'd3);
    check("R9 ds sends U3 req", d_txc, C_R3);
    d_rx(C_ACC);
    check("R3 enters U3", d_lvl, 3);
    d_exit(XU3, 3);

    // R9 and R10 upstream side
    u_req = 2'd3; tick(1); u_req = 2'd0;
    check("R9 up no U3 strobe", u_txv, 0);
    check("R9 up level", u_lvl, 0);
    u_tp = 1'b1; u_rxv = 1'b1; u_rxc = C_R3; tick(1); u_rxv = 1'b0; u_tp = 1'b0;
    check("R10 up accepts U3", u_txc, C_ACC);
    check("R10 up strobe", u_txv, 1);
    check("R10 up in U3", u_lvl, 3);
    u_rxv = 1'b1; u_rxc = C_REJ; tick(1); u_rxv = 1'b0;
    check("R6 up wake", u_wake, 1);
    tick(XU3);
    check("R7 up exit done", u_lvl, 0);

    // R5 random partner requests
    for (int i = 0; i < 40; i++) begin
      int c; bit tp, a1, a2; int e;
      c = int'($urandom_range(1, 0));
      tp = 1'($urandom_range(1, 0)); a1 = 1'($urandom_range(1, 0)); a2 = 1'($urandom_range(1, 0));
      e = exp_reply(c, tp, a1, a2);
      d_tp = tp; d_a1 = a1; d_a2 = a2;
      d_rx(3'(c));
      d_tp = 1'b0; d_a1 = 1'b1; d_a2 = 1'b1;
      check("R5 random reply", d_txc, e);
      check("R5 random level", d_lvl, (e == 3) ? c + 1 : 0);
      if (e == 3) d_exit((c == 0) ? XU1 : XU2, c + 1);
      else tick(1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule